// File: doc/BRIEF.md
# Odd-Power Table Address Generator

This block turns a table entry number and a word position into a RAM word address for a table of precomputed odd powers, as used by windowed modular exponentiation. Each table entry is as long as the modulus. When that length is an odd number of words, one spare word follows each entry, so every entry starts on a 64-bit boundary. The caller supplies the table base, the entry length field and the table size field. It then either asks for single addresses with a request strobe or starts a walk that steps through every stored word of every entry in order. A walk is used to load or clear the table.

Each address takes two cycles: the entry number times the stride goes into a register, and the sum and the range checks go into a second register. A request whose entry number, word position or final address falls outside the table is answered with an error pulse instead of an address. The configuration inputs are expected to stay stable while requests or a walk are in flight.

Top module: `optab_addr_gen`

## Requirements
- R1: An accepted request (from the strobe or from a walk step) is answered exactly two rising edges later, with either the valid pulse or the error pulse. Back-to-back requests are answered on back-to-back cycles.
- R2: The address equals base + entry·stride + word, where the length field holds words-per-entry minus one. The stride is the length field + 2 when the field is even, because the entry then has an odd word count and a spare word follows it. When the field is odd, the stride is the length field + 1.
- R3: A request whose entry number is above the table size field (entries minus one) gives the error pulse and no valid pulse.
- R4: A request whose word position is above the length field, including the spare word position, gives the error pulse and no valid pulse.
- R5: A computed address of 2048 or above, which does not fit in the 11-bit address, gives the error pulse and no valid pulse.
- R6: Valid and error are never high together. Both stay low in any cycle that answers no request.
- R7: After a walk start, each cycle with ready high issues the next word: words 0 to the length field within an entry, then the next entry, for entries 0 to the table size field. The spare words are skipped. A cycle with ready low issues nothing.
- R8: The last flag is high together with the answer for the final word of the final entry of a walk, and at no other time.
- R9: While a walk is running, the request strobe and a further walk start are ignored.
- R10: After reset, valid, error, last and the address are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base | input | 11 | Table base word address (even) |
| cfg_len | input | 10 | Words per entry minus one |
| cfg_last_idx | input | 5 | Number of entries minus one |
| req_valid | input | 1 | Single-address request strobe |
| req_index | input | 5 | Entry number of the request |
| req_offset | input | 10 | Word position within the entry, least significant word at 0 |
| walk_start | input | 1 | Begin a walk over the whole table |
| walk_ready | input | 1 | Consumer accepts one walk address this cycle |
| out_addr | output | 11 | Computed word address |
| out_valid | output | 1 | Address is valid |
| out_err | output | 1 | Request was out of range |
| out_last | output | 1 | Final word of a walk |

## Verification
The bench uses the default widths: an 11-bit address, a 10-bit length field and a 5-bit table size field. With these widths the 2048-word ceiling can be reached with a large entry length and a high base, so the overflow boundary is tested at 2047 and at 2048. Both stride cases are covered: a three-word entry with padding and a four-word entry without. A walk over three padded entries runs with ready toggling. During that walk, a conflicting strobe and a second start are applied to show they are ignored.

// File: rtl/optab_pkg.sv
package optab_pkg;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_t;

endpackage

// File: rtl/optab_stride.sv
module optab_stride #(
    parameter int LW = 10,
    localparam int SW = LW + 1
) (
    input  logic [LW-1:0] len,
    output logic [SW-1:0] stride
);

    // Entry holds len+1 words; an even len means an odd word count, so pad.
    always_comb begin
        stride = SW'(len) + SW'(1) + SW'(!len[0]);
    end

endmodule

// File: rtl/optab_walker.sv
module optab_walker
    import optab_pkg::*;
#(
    parameter int LW = 10,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ready,
    input  logic [LW-1:0] len,
    input  logic [IW-1:0] last_idx,
    output logic          busy,
    output logic          issue,
    output logic [IW-1:0] idx,
    output logic [LW-1:0] off,
    output logic          last
);

    typedef struct packed {
        walk_state_t   st;
        logic [IW-1:0] idx;
        logic [LW-1:0] off;
    } walk_t;

    walk_t w_d, w_q;
    logic  end_entry;
    logic  end_table;

    always_comb begin
        w_d       = w_q;
        end_entry = (w_q.off == len);
        end_table = end_entry && (w_q.idx == last_idx);
        issue     = (w_q.st == WALK_RUN) && ready;
        last      = issue && end_table;
        case (w_q.st)
            WALK_IDLE: begin
                if (start) begin
                    w_d.st  = WALK_RUN;
                    w_d.idx = '0;
                    w_d.off = '0;
                end
            end
            default: begin
                if (issue) begin
                    if (end_entry) begin
                        w_d.off = '0;
                        if (end_table) begin
                            w_d.st = WALK_IDLE;
                        end else begin
                            w_d.idx = w_q.idx + IW'(1);
                        end
                    end else begin
                        w_d.off = w_q.off + LW'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{st: WALK_IDLE, idx: '0, off: '0};
        end else begin
            w_q <= w_d;
        end
    end

    assign busy = (w_q.st == WALK_RUN);
    assign idx  = w_q.idx;
    assign off  = w_q.off;

endmodule

// File: rtl/optab_pipe.sv
module optab_pipe #(
    parameter int AW = 11,
    parameter int LW = 10,
    parameter int IW = 5,
    localparam int SW = LW + 1,
    localparam int PW = IW + SW,
    localparam int XW = ((PW > AW) ? PW : AW) + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic          in_last,
    input  logic [IW-1:0] in_idx,
    input  logic [LW-1:0] in_off,
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] len,
    input  logic [IW-1:0] last_idx,
    input  logic [SW-1:0] stride,
    output logic [AW-1:0] addr,
    output logic          valid,
    output logic          err,
    output logic          last
);

    typedef struct packed {
        logic          vld;
        logic          last;
        logic          bad;
        logic [PW-1:0] prod;
        logic [XW-1:0] bo;
    } stage1_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          valid;
        logic          err;
        logic          last;
    } stage2_t;

    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;
    logic [XW-1:0] sum;
    logic          ovf;

    always_comb begin
        // stage 1: product and range checks on the request fields
        s1_d.vld  = in_vld;
        s1_d.last = in_vld && in_last;
        s1_d.bad  = (in_idx > last_idx) || (in_off > len);
        s1_d.prod = PW'(in_idx) * PW'(stride);
        s1_d.bo   = XW'(base) + XW'(in_off);

        // stage 2: final sum and address range check
        sum        = XW'(s1_q.prod) + s1_q.bo;
        ovf        = |sum[XW-1:AW];
        s2_d.valid = s1_q.vld && !s1_q.bad && !ovf;
        s2_d.err   = s1_q.vld && (s1_q.bad || ovf);
        s2_d.addr  = s2_d.valid ? sum[AW-1:0] : '0;
        s2_d.last  = s1_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign addr  = s2_q.addr;
    assign valid = s2_q.valid;
    assign err   = s2_q.err;
    assign last  = s2_q.last;

endmodule

// File: rtl/optab_addr_gen.sv
module optab_addr_gen #(
    parameter int AW = 11,
    parameter int LW = 10,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [LW-1:0] cfg_len,
    input  logic [IW-1:0] cfg_last_idx,
    input  logic          req_valid,
    input  logic [IW-1:0] req_index,
    input  logic [LW-1:0] req_offset,
    input  logic          walk_start,
    input  logic          walk_ready,
    output logic [AW-1:0] out_addr,
    output logic          out_valid,
    output logic          out_err,
    output logic          out_last
);

    localparam int SW = LW + 1;

    logic [SW-1:0] stride;
    logic          walk_busy;
    logic          walk_issue;
    logic [IW-1:0] walk_idx;
    logic [LW-1:0] walk_off;
    logic          walk_last;

    logic          pipe_vld;
    logic          pipe_last;
    logic [IW-1:0] pipe_idx;
    logic [LW-1:0] pipe_off;

    optab_stride #(.LW(LW)) u_stride (
        .len    (cfg_len),
        .stride (stride)
    );

    optab_walker #(.LW(LW), .IW(IW)) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (walk_start),
        .ready    (walk_ready),
        .len      (cfg_len),
        .last_idx (cfg_last_idx),
        .busy     (walk_busy),
        .issue    (walk_issue),
        .idx      (walk_idx),
        .off      (walk_off),
        .last     (walk_last)
    );

    // The walker owns the pipeline input while it runs.
    always_comb begin
        if (walk_busy) begin
            pipe_vld  = walk_issue;
            pipe_last = walk_last;
            pipe_idx  = walk_idx;
            pipe_off  = walk_off;
        end else begin
            pipe_vld  = req_valid;
            pipe_last = 1'b0;
            pipe_idx  = req_index;
            pipe_off  = req_offset;
        end
    end

    optab_pipe #(.AW(AW), .LW(LW), .IW(IW)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (pipe_vld),
        .in_last  (pipe_last),
        .in_idx   (pipe_idx),
        .in_off   (pipe_off),
        .base     (cfg_base),
        .len      (cfg_len),
        .last_idx (cfg_last_idx),
        .stride   (stride),
        .addr     (out_addr),
        .valid    (out_valid),
        .err      (out_err),
        .last     (out_last)
    );

endmodule

// File: rtl/optab_addr_gen_chk.sv
module optab_addr_gen_chk #(
    parameter int AW = 11,
    parameter int LW = 10,
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] cfg_base,
    input logic [LW-1:0] cfg_len,
    input logic [IW-1:0] cfg_last_idx,
    input logic          pipe_vld,
    input logic [IW-1:0] pipe_idx,
    input logic [LW-1:0] pipe_off,
    input logic [AW-1:0] out_addr,
    input logic          out_valid,
    input logic          out_err,
    input logic          out_last
);

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_err));

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || out_err) |-> $past(pipe_vld, 2));

    p_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid || out_err));

    p_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(pipe_idx, 2) <= cfg_last_idx));

    p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(pipe_off, 2) <= cfg_len));

    p_even_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cfg_base[0] && ($past(pipe_off, 2) == '0)) |-> !out_addr[0]);

    p_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_addr >= cfg_base));

endmodule

bind optab_addr_gen optab_addr_gen_chk #(.AW(AW), .LW(LW), .IW(IW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_base     (cfg_base),
    .cfg_len      (cfg_len),
    .cfg_last_idx (cfg_last_idx),
    .pipe_vld     (pipe_vld),
    .pipe_idx     (pipe_idx),
    .pipe_off     (pipe_off),
    .out_addr     (out_addr),
    .out_valid    (out_valid),
    .out_err      (out_err),
    .out_last     (out_last)
);

// File: tb/optab_addr_gen_test.sv
module optab_addr_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int LW = 10;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [LW-1:0] cfg_len = '0;
    logic [IW-1:0] cfg_last_idx = '0;
    logic          req_valid = 1'b0;
    logic [IW-1:0] req_index = '0;
    logic [LW-1:0] req_offset = '0;
    logic          walk_start = 1'b0;
    logic          walk_ready = 1'b0;
    logic [AW-1:0] out_addr;
    logic          out_valid;
    logic          out_err;
    logic          out_last;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    optab_addr_gen #(.AW(AW), .LW(LW), .IW(IW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_base     (cfg_base),
        .cfg_len      (cfg_len),
        .cfg_last_idx (cfg_last_idx),
        .req_valid    (req_valid),
        .req_index    (req_index),
        .req_offset   (req_offset),
        .walk_start   (walk_start),
        .walk_ready   (walk_ready),
        .out_addr     (out_addr),
        .out_valid    (out_valid),
        .out_err      (out_err),
        .out_last     (out_last)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int base, input int len, input int last);
        @(negedge clk);
        cfg_base     = AW'(base);
        cfg_len      = LW'(len);
        cfg_last_idx = IW'(last);
    endtask

    function automatic void model(input int idx, input int off, output int a, output bit e);
        int words;
        int stride;
        words  = int'(cfg_len) + 1;
        stride = (words % 2 == 1) ? words + 1 : words;
        a = int'(cfg_base) + idx * stride + off;
        e = (idx > int'(cfg_last_idx)) || (off > int'(cfg_len)) || (a >= 2048);
    endfunction

    // One isolated request; checks silence after one edge and the answer after two.
    task automatic check_req(input int idx, input int off, input string tag);
        int  a;
        bit  e;
        model(idx, off, a, e);
        @(negedge clk);
        req_valid  = 1'b1;
        req_index  = IW'(idx);
        req_offset = LW'(off);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!out_valid && !out_err, "R1 nothing after one edge", int'(out_valid | out_err), 0);
        @(negedge clk);
        chk(out_err == e, {tag, " err"}, int'(out_err), int'(e));
        chk(out_valid == !e, {tag, " valid"}, int'(out_valid), int'(!e));
        if (!e) chk(int'(out_addr) == a, {tag, " addr"}, int'(out_addr), a);
    endtask

    task automatic t_reset;
        chk(!out_valid && !out_err && !out_last && out_addr == '0, "R10 reset outputs",
            int'({out_valid, out_err, out_last}) + int'(out_addr), 0);
    endtask

    task automatic t_stride_padded;
        set_cfg(100, 2, 3);      // 3 words -> stride 4
        check_req(0, 0, "R2 padded e0w0");
        check_req(1, 0, "R2 padded e1w0");
        check_req(3, 2, "R2 padded e3w2");
    endtask

    task automatic t_stride_plain;
        set_cfg(200, 3, 4);      // 4 words -> stride 4, no pad
        check_req(2, 1, "R2 plain e2w1");
        set_cfg(40, 4, 4);       // 5 words -> stride 6
        check_req(4, 4, "R2 padded5 e4w4");
    endtask

    task automatic t_bad_index;
        set_cfg(100, 2, 3);
        check_req(4, 0, "R3 index above table");
        check_req(31, 1, "R3 index max");
    endtask

    task automatic t_bad_offset;
        set_cfg(100, 2, 3);
        check_req(1, 3, "R4 spare word position");
        check_req(0, 1023, "R4 offset max");
    endtask

    task automatic t_overflow;
        set_cfg(1916, 130, 1);   // 131 words -> stride 132
        check_req(0, 130, "R5 top word 2046");
        check_req(1, 0, "R5 entry over 2048");
        set_cfg(2000, 130, 0);
        check_req(0, 47, "R5 exactly 2047");
        check_req(0, 48, "R5 exactly 2048");
    endtask

    task automatic t_stream;
        int a [3];
        bit e [3];
        set_cfg(10, 2, 2);
        for (int i = 0; i < 3; i++) model(i, i, a[i], e[i]);
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            req_valid  = 1'b1;
            req_index  = IW'(i);
            req_offset = LW'(i);
            @(negedge clk);
            if (i > 0) chk(out_valid && int'(out_addr) == a[i-1], "R1 back-to-back",
                           int'(out_addr), a[i-1]);
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk(out_valid && int'(out_addr) == a[2], "R1 back-to-back tail", int'(out_addr), a[2]);
        @(negedge clk);
        chk(!out_valid && !out_err, "R6 idle after stream", int'(out_valid | out_err), 0);
    endtask

    task automatic t_walk;
        int exp_addr [9];
        int k = 0;
        int lasts = 0;
        int errs = 0;
        set_cfg(100, 2, 2);      // 3 entries x 3 words, stride 4
        for (int en = 0; en < 3; en++)
            for (int w = 0; w < 3; w++) exp_addr[en*3 + w] = 100 + en*4 + w;
        @(negedge clk);
        walk_start = 1'b1;
        walk_ready = 1'b0;
        @(negedge clk);
        walk_start = 1'b0;
        req_valid  = 1'b1;       // R9: conflicting strobe while walking
        req_index  = IW'(31);
        req_offset = '0;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(!out_valid && !out_err, "R7 ready low issues nothing",
                int'(out_valid | out_err), 0);
        end
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (out_err) errs++;
            if (out_last) lasts++;
            if (out_valid) begin
                if (k < 9) begin
                    chk(int'(out_addr) == exp_addr[k], "R7 walk order", int'(out_addr), exp_addr[k]);
                    chk(out_last == (k == 8), "R8 last flag position", int'(out_last), int'(k == 8));
                end
                k++;
            end
            walk_ready = (c % 3 != 2);
            walk_start = (c == 4);  // R9: restart attempt mid-walk
            req_valid  = (c < 9);
        end
        walk_ready = 1'b0;
        walk_start = 1'b0;
        req_valid  = 1'b0;
        chk(k == 9, "R7 walk word count", k, 9);
        chk(errs == 0, "R9 strobe ignored during walk", errs, 0);
        chk(lasts == 1, "R8 single last", lasts, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        chk(!out_valid && !out_err, "R6 idle no request", int'(out_valid | out_err), 0);
        t_stride_padded();
        t_stride_plain();
        t_bad_index();
        t_bad_offset();
        t_overflow();
        t_stream();
        t_walk();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule